// File: doc/BRIEF.md
# Two-Rank Fast-Read Binary Counter

This block is a binary up-counter where each order keeps two bits. The stored bit holds the count. The steering bit decides where the next increment lands. On a count strobe, the increment starts at the lowest order and moves up through every order whose steering bit is one, clearing the stored bit there. It stops at the first order whose steering bit is zero and sets the stored bit of that order. Orders above that one keep their values. A separate gate-set strobe copies all stored bits into the steering bits at the same moment. This readies the counter for the next increment.

The intended use alternates the two strobes: a count strobe, then a gate-set strobe in some later cycle. Because of this, the stored value is final one clock after the count strobe, and no carry ripples through the stored rank while it is read. A synchronous clear and a parallel load are also provided. All pins are plain level or strobe signals. Every operation completes in one clock, so there is no valid/ready handshake and no back-pressure: a strobe is accepted in any cycle it is high. Operations are priority-ordered in the cycle they arrive, from highest to lowest: clear, load, count, gate copy.

Top module: `fzc_counter`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, the stored bits, the steering bits and the carry flag are all zero.
- R2: On a count strobe, every order below the lowest order whose steering bit is zero has its stored bit cleared.
- R3: On a count strobe, the stored bit of the lowest order whose steering bit is zero is set, and all stored bits above it keep their values.
- R4: A count strobe takes its steering from the steering bits, not from the stored bits. The steering bits do not change on a count strobe, so a second count strobe with no gate-set between them steers the same way as the first.
- R5: A gate-set strobe with no higher-priority operation copies every stored bit into its steering bit on the next clock edge and leaves the stored bits unchanged.
- R6: When a count strobe and a gate-set strobe arrive in the same cycle, the count is applied on that edge with the steering bits held. The copy of stored into steering bits happens on the following edge, even with no further strobe.
- R7: A count strobe when all steering bits are one clears every stored bit. The carry flag is then high for exactly the one cycle after that edge and low otherwise.
- R8: The synchronous clear zeroes both ranks and the carry flag on the next edge, overriding load, count and gate-set in the same cycle.
- R9: A load writes the load value into both the stored bits and the steering bits on the next edge, overriding count and gate-set in the same cycle.
- R10: Alternating count and gate-set strobes from zero step the stored value through successive binary values, each visible one clock after its count strobe, and wrapping modulo 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of both ranks |
| load_i | input | 1 | Parallel load strobe |
| load_val_i | input | WIDTH | Value written into both ranks on load |
| count_i | input | 1 | Increment strobe (pulse-present phase) |
| gate_set_i | input | 1 | Copy stored bits into steering bits (no-pulse phase) |
| hold_o | output | WIDTH | Stored count |
| gate_o | output | WIDTH | Steering bits |
| carry_o | output | 1 | One-cycle flag after a wrapping count |

## Verification
The bench builds the counter with WIDTH = 4. At that width, the wrap from all ones to zero and the carry flag can be reached within a run of sixteen alternating count and gate-set pairs. The narrow width also lets hand-chosen load patterns place the first zero of the steering bits at every order, including the top order and none at all. Loading patterns where the stored and steering bits differ brings the stale-steering case and the untouched upper orders into view.

// File: rtl/fzc_pkg.sv
package fzc_pkg;
  typedef enum logic [2:0] {
    FZC_IDLE  = 3'd0,
    FZC_CLEAR = 3'd1,
    FZC_LOAD  = 3'd2,
    FZC_COUNT = 3'd3,
    FZC_COPY  = 3'd4
  } fzc_op_e;
endpackage

// File: rtl/fzc_steer.sv
module fzc_steer #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] gate_i,
  output logic [WIDTH-1:0] clr_o,
  output logic [WIDTH-1:0] set_o,
  output logic             wrap_o
);
  localparam int NPASS = WIDTH + 1;
  logic [NPASS-1:0] pass;

  assign pass[0] = 1'b1;
  for (genvar i = 0; i < WIDTH; i++) begin : g_chain
    // the increment reaches order i+1 only through a steering one at order i
    assign pass[i+1] = pass[i] & gate_i[i];
    assign clr_o[i]  = pass[i] & gate_i[i];
    assign set_o[i]  = pass[i] & ~gate_i[i];
  end
  assign wrap_o = pass[WIDTH];
endmodule

// File: rtl/fzc_order.sv
module fzc_order
  import fzc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  fzc_op_e op_i,
  input  logic    load_bit_i,
  input  logic    clr_i,
  input  logic    set_i,
  output logic    hold_o,
  output logic    gate_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_o <= 1'b0;
      gate_o <= 1'b0;
    end else begin
      case (op_i)
        FZC_CLEAR: begin
          hold_o <= 1'b0;
          gate_o <= 1'b0;
        end
        FZC_LOAD: begin
          hold_o <= load_bit_i;
          gate_o <= load_bit_i;
        end
        FZC_COUNT: begin
          if (clr_i)      hold_o <= 1'b0;
          else if (set_i) hold_o <= 1'b1;
        end
        FZC_COPY: gate_o <= hold_o;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fzc_counter.sv
module fzc_counter
  import fzc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             count_i,
  input  logic             gate_set_i,
  output logic [WIDTH-1:0] hold_o,
  output logic [WIDTH-1:0] gate_o,
  output logic             carry_o
);
  fzc_op_e          op;
  logic             copy_pend_q;
  logic [WIDTH-1:0] clr_v, set_v;
  logic             wrap;

  always_comb begin
    if (clear_i)                        op = FZC_CLEAR;
    else if (load_i)                    op = FZC_LOAD;
    else if (count_i)                   op = FZC_COUNT;
    else if (gate_set_i || copy_pend_q) op = FZC_COPY;
    else                                op = FZC_IDLE;
  end

  fzc_steer #(.WIDTH(WIDTH)) u_steer (
    .gate_i (gate_o),
    .clr_o  (clr_v),
    .set_o  (set_v),
    .wrap_o (wrap)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_order
    fzc_order u_order (
      .clk        (clk),
      .rst_n      (rst_n),
      .op_i       (op),
      .load_bit_i (load_val_i[i]),
      .clr_i      (clr_v[i]),
      .set_i      (set_v[i]),
      .hold_o     (hold_o[i]),
      .gate_o     (gate_o[i])
    );
  end

  // a gate-set colliding with a count is remembered and served next cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_pend_q <= 1'b0;
      carry_o     <= 1'b0;
    end else begin
      copy_pend_q <= (op == FZC_COUNT) && gate_set_i;
      carry_o     <= (op == FZC_COUNT) && wrap;
    end
  end
endmodule

// File: rtl/fzc_counter_chk.sv
module fzc_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             load_i,
  input logic [WIDTH-1:0] load_val_i,
  input logic             count_i,
  input logic             gate_set_i,
  input logic [WIDTH-1:0] hold_o,
  input logic [WIDTH-1:0] gate_o,
  input logic             carry_o
);
  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (hold_o == '0 && gate_o == '0 && !carry_o));

  assert_load_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> (hold_o == $past(load_val_i) && gate_o == $past(load_val_i)));

  assert_count_keeps_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i && !load_i && !clear_i) |=> $stable(gate_o));

  assert_gate_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_set_i && !count_i && !load_i && !clear_i) |=>
      (gate_o == $past(hold_o) && $stable(hold_o)));

  assert_increment_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i && !load_i && !clear_i && gate_o == hold_o) |=>
      hold_o == WIDTH'($past(hold_o) + 1'b1));

  assert_carry_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> $past(count_i && !load_i && !clear_i && (&gate_o)));
endmodule

bind fzc_counter fzc_counter_chk #(.WIDTH(WIDTH)) u_fzc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear_i    (clear_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .count_i    (count_i),
  .gate_set_i (gate_set_i),
  .hold_o     (hold_o),
  .gate_o     (gate_o),
  .carry_o    (carry_o)
);

// File: tb/test_fzc_counter.sv
`timescale 1ns/1ps
module test_fzc_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clear_i = 1'b0, load_i = 1'b0, count_i = 1'b0, gate_set_i = 1'b0;
  logic [W-1:0] load_val_i = '0;
  logic [W-1:0] hold_o, gate_o;
  logic         carry_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fzc_counter #(.WIDTH(W)) i_fzc_counter (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .load_i(load_i),
    .load_val_i(load_val_i), .count_i(count_i), .gate_set_i(gate_set_i),
    .hold_o(hold_o), .gate_o(gate_o), .carry_o(carry_o)
  );

  task automatic expect_val(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive one cycle of strobes starting at a falling edge; returns after the
  // next falling edge, when the registered result of that rising edge is visible
  task automatic step(bit cl, bit ld, logic [W-1:0] v, bit c, bit g);
    clear_i = cl; load_i = ld; load_val_i = v; count_i = c; gate_set_i = g;
    @(negedge clk);
    clear_i = 0; load_i = 0; load_val_i = '0; count_i = 0; gate_set_i = 0;
  endtask

  task automatic t_reset;
    expect_val("R1", "hold in reset", hold_o, '0);
    expect_val("R1", "gate in reset", gate_o, '0);
    expect_val("R1", "carry in reset", {3'b0, carry_o}, '0);
    rst_n = 1'b1;
    step(0, 0, '0, 0, 0);
    expect_val("R1", "hold after release", hold_o, '0);
    expect_val("R1", "gate after release", gate_o, '0);
  endtask

  task automatic t_sequence;
    logic [W-1:0] e = '0;
    step(1, 0, '0, 0, 0);
    for (int n = 0; n < 18; n++) begin
      logic wrapped = (e == {W{1'b1}});
      step(0, 0, '0, 1, 0);
      e = e + 1'b1;
      expect_val("R10", "hold after count", hold_o, e);
      expect_val("R7", "carry after count", {3'b0, carry_o}, {3'b0, wrapped});
      step(0, 0, '0, 0, 1);
      expect_val("R5", "gate after gate-set", gate_o, e);
      expect_val("R5", "hold kept by gate-set", hold_o, e);
    end
  endtask

  task automatic t_steering;
    step(0, 1, 4'b0011, 0, 0);
    expect_val("R9", "load hold", hold_o, 4'b0011);
    expect_val("R9", "load gate", gate_o, 4'b0011);
    step(0, 0, '0, 1, 0);
    expect_val("R2", "low orders cleared", hold_o, 4'b0100);
    expect_val("R4", "gate held on count", gate_o, 4'b0011);
    step(0, 0, '0, 1, 0);
    expect_val("R4", "stale steering repeats", hold_o, 4'b0100);
    step(0, 1, 4'b1001, 0, 0);
    step(0, 0, '0, 1, 0);
    expect_val("R3", "first zero set, top kept", hold_o, 4'b1010);
    step(0, 1, 4'b0111, 0, 0);
    step(0, 0, '0, 1, 0);
    expect_val("R3", "top order set", hold_o, 4'b1000);
  endtask

  task automatic t_collision;
    step(0, 1, 4'b0001, 0, 0);
    step(0, 0, '0, 1, 1);
    expect_val("R6", "count applied", hold_o, 4'b0010);
    expect_val("R6", "gate deferred", gate_o, 4'b0001);
    step(0, 0, '0, 0, 0);
    expect_val("R6", "gate copied next cycle", gate_o, 4'b0010);
    expect_val("R6", "hold unchanged", hold_o, 4'b0010);
  endtask

  task automatic t_wrap;
    step(0, 1, 4'b1111, 0, 0);
    step(0, 0, '0, 1, 0);
    expect_val("R7", "wrap hold", hold_o, 4'b0000);
    expect_val("R7", "carry raised", {3'b0, carry_o}, 4'b0001);
    step(0, 0, '0, 0, 0);
    expect_val("R7", "carry one cycle", {3'b0, carry_o}, 4'b0000);
  endtask

  task automatic t_priority;
    step(0, 1, 4'b0110, 0, 0);
    step(1, 1, 4'b1011, 1, 1);
    expect_val("R8", "clear hold", hold_o, '0);
    expect_val("R8", "clear gate", gate_o, '0);
    step(0, 1, 4'b0101, 1, 1);
    expect_val("R9", "load over count hold", hold_o, 4'b0101);
    expect_val("R9", "load over count gate", gate_o, 4'b0101);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_sequence();
    t_steering();
    t_collision();
    t_wrap();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule